// File: doc/BRIEF.md
# CAN bus-off recovery sequencer

This block carries a CAN node through the recovery it must finish after entering the bus-off state. When the protocol engine reports bus-off, the sequencer sets the init control bit by itself and withholds the bus-activity enable. It then waits for software to clear init. Only after that does it watch the sampled bus levels, one sample per bit-valid strobe, for idle periods. An idle period is eleven consecutive recessive samples.

Each completed idle period adds one to a receive-error-style count. It also raises a one-cycle strobe that makes the status reporter record a bit-0 error code. Software can follow this strobe to see that recovery is moving and that the bus is not stuck dominant. When the 129th idle period completes, the sequencer pulses an error-counter reset for one cycle and returns to normal operation. Software writes to init cannot make this sequence shorter. Setting init during the wait only pauses the counting.

Top module: `can_busoff_recovery`

## Requirements
- R1: In the normal state, a high `busoff_i` sets `init_o` to 1 and `bus_en_o` to 0 from the next cycle. It also clears `run_cnt_o` to 0, and it takes priority over a CPU write in the same cycle. A `busoff_i` pulse in any other state has no effect.
- R2: After bus-off entry no sample is counted while init is still set, and a CPU write of init=1 keeps the block waiting. Recovery starts only on the cycle after a CPU write of init=0 (`cpu_wr_i`=1, `cpu_init_i`=0).
- R3: During recovery, a CPU write of init=1 pauses counting. While paused, samples do not change `run_cnt_o`, and the completed count and the partly built run are both kept. A later write of init=0 resumes counting where it stopped.
- R4: During recovery, eleven consecutive recessive samples (`bit_valid_i`=1, `bit_level_i`=1 means recessive) complete one run. On the clock edge that takes the eleventh sample, `run_cnt_o` increases by one, and `lec_bit0_o` is high for exactly the following cycle. Cycles with `bit_valid_i`=0 change nothing.
- R5: A dominant sample (`bit_level_i`=0) resets the partial run to zero and does not lower `run_cnt_o`. The run length restarts at zero after each completed run, so runs never overlap: 22 recessive samples give exactly two runs.
- R6: The edge that completes the 129th run sets `run_cnt_o` to 129. In the cycle that follows, `err_reset_o` is high. After that single cycle the block is back in normal: `run_cnt_o` is 0, `err_reset_o` is 0, and `bus_en_o` follows init.
- R7: After reset, `init_o` is 0, `bus_en_o` is 1, `run_cnt_o` is 0, and `lec_bit0_o` and `err_reset_o` are 0.
- R8: In the normal state, a CPU write sets `init_o` to `cpu_init_i` on the next cycle, and `bus_en_o` is the inverse of `init_o`. Samples leave `run_cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busoff_i | input | 1 | Bus-off entry pulse from the error counters |
| bit_valid_i | input | 1 | Strobe marking a new sampled bus bit |
| bit_level_i | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| cpu_wr_i | input | 1 | CPU write strobe for the init bit |
| cpu_init_i | input | 1 | Value written to the init bit |
| init_o | output | 1 | Current init bit |
| bus_en_o | output | 1 | Bus activity allowed |
| run_cnt_o | output | 8 | Completed recessive runs in this recovery |
| lec_bit0_o | output | 1 | One-cycle strobe: record a bit-0 error code |
| err_reset_o | output | 1 | One-cycle pulse: reset the error counters |

## Verification
The hardest situation to reach is a pause in the middle of a run followed by a resume, where the completed count and the partial run length must both survive. The stimulus builds six recessive samples and then sets init. It sends twenty recessive samples while paused, clears init, and checks that exactly five more samples complete the next run. The 129th-run boundary is also hard to reach. The stimulus gets there by looping whole runs up to 128, then checks the cycles just before, on and after the final sample. Throughout, a behavioural model in the bench is compared with every output on every clock.

// File: rtl/can_boff_pkg.sv
// Package: shared types for the bus-off recovery sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package can_boff_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_WAIT_CLR = 2'd1,
        ST_RECOVER  = 2'd2,
        ST_DONE     = 2'd3
    } boff_state_e;

endpackage

// File: rtl/boff_ctrl_fsm.sv
// Module: boff_ctrl_fsm
// Holds the sequencer phase and the init bit. Bus-off entry forces init and
// beats a CPU write in the same cycle. A CPU write of init=0 while waiting
// starts recovery. The final run moves to DONE, which lasts one cycle.
// Assumes: last_run_i is high only in ST_RECOVER, on the edge of the final run.
module boff_ctrl_fsm
    import can_boff_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busoff_i,
    input  logic        cpu_wr_i,
    input  logic        cpu_init_i,
    input  logic        last_run_i,
    output boff_state_e state_o,
    output logic        init_o
);

    boff_state_e state_q, state_d;
    logic        init_q, init_d;

    // Next-phase decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:   if (busoff_i) state_d = ST_WAIT_CLR;
            ST_WAIT_CLR: if (cpu_wr_i && !cpu_init_i) state_d = ST_RECOVER;
            ST_RECOVER:  if (last_run_i) state_d = ST_DONE;
            ST_DONE:     state_d = ST_NORMAL;
            default:     state_d = ST_NORMAL;
        endcase
    end

    // Next init value: bus-off entry forces it, otherwise CPU writes apply
    always_comb begin
        init_d = init_q;
        if (state_q == ST_NORMAL && busoff_i) init_d = 1'b1;
        else if (cpu_wr_i)                    init_d = cpu_init_i;
    end

    // State and init registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            init_q  <= init_d;
        end
    end

    assign state_o = state_q;
    assign init_o  = init_q;

    AST_BUSOFF_SETS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && busoff_i) |=> (init_q && state_q == ST_WAIT_CLR)); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_NORMAL)); // R6
    AST_WAIT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CLR && !(cpu_wr_i && !cpu_init_i)) |=> (state_q == ST_WAIT_CLR)); // R2

endmodule

// File: rtl/boff_run_len.sv
// Module: boff_run_len
// Measures the current run of consecutive recessive samples. It flags the
// sample that completes a run and restarts at zero, so runs never overlap.
// A dominant sample restarts the run. When not enabled the length is held.
// Assumes: clr_i and en_i are never high together.
module boff_run_len #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic bit_valid_i,
    input  logic bit_level_i,
    output logic run_done_o
);

    localparam int LEN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(RUN_LEN - 1);

    logic [LEN_W-1:0] len_q;
    logic             take;

    assign take       = en_i && bit_valid_i;
    assign run_done_o = take && bit_level_i && (len_q == LEN_LAST);

    // Run-length register
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            len_q <= '0;
        end else if (take) begin
            if (!bit_level_i || run_done_o) len_q <= '0;
            else                            len_q <= len_q + 1'b1;
        end
    end

    AST_RUN_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_LAST); // R5
    AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bit_level_i) |=> (len_q == '0)); // R5
    AST_PAUSE_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(len_q)); // R3

endmodule

// File: rtl/boff_run_count.sv
// Module: boff_run_count
// Counts completed idle runs and raises the one-cycle bit-0 error strobe for
// each one. It flags when the next run will be the last one needed.
// Assumes: inc_i is a single-cycle flag per run and never meets clr_i.
module boff_run_count #(
    parameter int RUNS_NEEDED = 129,
    parameter int REC_W       = $clog2(RUNS_NEEDED + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [REC_W-1:0] cnt_o,
    output logic             at_last_o,
    output logic             lec_o
);

    localparam logic [REC_W-1:0] CNT_LAST = REC_W'(RUNS_NEEDED - 1);
    localparam logic [REC_W-1:0] CNT_MAX  = REC_W'(RUNS_NEEDED);

    logic [REC_W-1:0] cnt_q;
    logic             lec_q;

    // Completed-run counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (inc_i)      cnt_q <= cnt_q + 1'b1;
    end

    // Bit-0 error strobe, one cycle per run
    always_ff @(posedge clk) begin
        if (!rst_n) lec_q <= 1'b0;
        else        lec_q <= inc_i;
    end

    assign cnt_o     = cnt_q;
    assign at_last_o = (cnt_q == CNT_LAST);
    assign lec_o     = lec_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R6
    AST_STROBE_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        lec_q |-> (cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/can_busoff_recovery.sv
// Module: can_busoff_recovery (top)
// Bus-off recovery sequencer. It forces init on bus-off entry and waits for
// software to clear it. It then counts idle runs of recessive samples, giving
// one bit-0 error strobe per run. After the last run it pulses the
// error-counter reset and returns to normal.
// Assumes: the samples are already bit-timed; bit_level_i=1 is recessive.
module can_busoff_recovery
    import can_boff_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int RUNS_NEEDED = 129,
    parameter int REC_W       = $clog2(RUNS_NEEDED + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busoff_i,
    input  logic             bit_valid_i,
    input  logic             bit_level_i,
    input  logic             cpu_wr_i,
    input  logic             cpu_init_i,
    output logic             init_o,
    output logic             bus_en_o,
    output logic [REC_W-1:0] run_cnt_o,
    output logic             lec_bit0_o,
    output logic             err_reset_o
);

    boff_state_e state;
    logic        init_bit;
    logic        count_en;
    logic        len_clr;
    logic        run_done;
    logic        cnt_clr;
    logic        at_last;
    logic        last_run;

    // Counting only happens in recovery with init cleared
    assign count_en = (state == ST_RECOVER) && !init_bit;
    assign len_clr  = (state == ST_NORMAL);
    assign cnt_clr  = (state == ST_DONE) || (state == ST_NORMAL && busoff_i);
    assign last_run = run_done && at_last;

    boff_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busoff_i   (busoff_i),
        .cpu_wr_i   (cpu_wr_i),
        .cpu_init_i (cpu_init_i),
        .last_run_i (last_run),
        .state_o    (state),
        .init_o     (init_bit)
    );

    boff_run_len #(.RUN_LEN(RUN_LEN)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (len_clr),
        .en_i        (count_en),
        .bit_valid_i (bit_valid_i),
        .bit_level_i (bit_level_i),
        .run_done_o  (run_done)
    );

    boff_run_count #(.RUNS_NEEDED(RUNS_NEEDED), .REC_W(REC_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cnt_clr),
        .inc_i     (run_done),
        .cnt_o     (run_cnt_o),
        .at_last_o (at_last),
        .lec_o     (lec_bit0_o)
    );

    assign init_o      = init_bit;
    assign bus_en_o    = (state == ST_NORMAL) && !init_bit;
    assign err_reset_o = (state == ST_DONE);

    AST_NO_COUNT_WHILE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CLR || (state == ST_RECOVER && init_bit)) |=> $stable(run_cnt_o)); // R3
    AST_ERR_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset_o |=> (run_cnt_o == '0 && !err_reset_o)); // R6
    AST_NORMAL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && !busoff_i) |=> $stable(run_cnt_o)); // R8

endmodule

// File: tb/can_busoff_recovery_tb.sv
// Bench for can_busoff_recovery: a behavioural reference model is compared on
// every clock, and directed checks cover each requirement.
module can_busoff_recovery_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RUNS       = 129;
    localparam int RLEN       = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busoff_i = 1'b0, bit_valid_i = 1'b0, bit_level_i = 1'b0;
    logic       cpu_wr_i = 1'b0, cpu_init_i = 1'b0;
    logic       init_o, bus_en_o, lec_bit0_o, err_reset_o;
    logic [7:0] run_cnt_o;

    int    checks = 0, errors = 0, cycles = 0;
    string phase = "R7";
    bit    finished = 1'b0;

    // model state: 0 normal, 1 waiting, 2 recovering, 3 done
    int ms = 0, mlen = 0, mcnt = 0;
    bit mi = 0, mlec = 0;

    can_busoff_recovery u_dut (
        .clk(clk), .rst_n(rst_n), .busoff_i(busoff_i), .bit_valid_i(bit_valid_i),
        .bit_level_i(bit_level_i), .cpu_wr_i(cpu_wr_i), .cpu_init_i(cpu_init_i),
        .init_o(init_o), .bus_en_o(bus_en_o), .run_cnt_o(run_cnt_o),
        .lec_bit0_o(lec_bit0_o), .err_reset_o(err_reset_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, then compare one time unit after the edge
    always @(posedge clk) begin
        bit nlec;
        cycles++;
        nlec = 1'b0;
        if (!rst_n) begin
            ms = 0; mi = 0; mlen = 0; mcnt = 0;
        end else if (ms == 3) begin
            ms = 0; mcnt = 0;
            if (cpu_wr_i) mi = cpu_init_i;
        end else if (ms == 0) begin
            if (busoff_i) begin ms = 1; mi = 1; mcnt = 0; mlen = 0; end
            else if (cpu_wr_i) mi = cpu_init_i;
        end else if (ms == 1) begin
            if (cpu_wr_i) begin mi = cpu_init_i; if (!cpu_init_i) ms = 2; end
        end else begin
            if (!mi && bit_valid_i) begin
                if (!bit_level_i) mlen = 0;
                else begin
                    mlen++;
                    if (mlen == RLEN) begin
                        mlen = 0; mcnt++; nlec = 1'b1;
                        if (mcnt == RUNS) ms = 3;
                    end
                end
            end
            if (cpu_wr_i) mi = cpu_init_i;
        end
        mlec = nlec;
        #1;
        if (rst_n && !finished) begin
            check(init_o == mi, {phase, " model init"}, init_o, mi);
            check(bus_en_o == (ms == 0 && !mi), {phase, " model bus_en"}, bus_en_o, (ms == 0 && !mi));
            check(run_cnt_o == mcnt[7:0], {phase, " model count"}, run_cnt_o, mcnt);
            check(lec_bit0_o == mlec, {phase, " model lec"}, lec_bit0_o, mlec);
            check(err_reset_o == (ms == 3), {phase, " model err_reset"}, err_reset_o, (ms == 3));
        end
    end

    task automatic drive(input bit bo, input bit v, input bit l, input bit w, input bit ci);
        @(negedge clk);
        busoff_i = bo; bit_valid_i = v; bit_level_i = l; cpu_wr_i = w; cpu_init_i = ci;
    endtask
    task automatic idle();                 drive(0, 0, 0, 0, 0); endtask
    task automatic sbit(input bit l);      drive(0, 1, l, 0, 0); endtask
    task automatic cpu(input bit v);       drive(0, 0, 0, 1, v); endtask
    task automatic recs(input int n);      for (int i = 0; i < n; i++) sbit(1'b1); endtask
    task automatic settle();               @(posedge clk); #2; endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        phase = "R7";
        check(init_o == 0 && bus_en_o == 1, "R7 reset init/bus_en", {init_o, bus_en_o}, 1);
        check(run_cnt_o == 0 && !lec_bit0_o && !err_reset_o, "R7 reset count/strobes", run_cnt_o, 0);

        phase = "R8";
        recs(15); idle(); settle();
        check(run_cnt_o == 0, "R8 no counting in normal", run_cnt_o, 0);
        cpu(1'b1); idle(); settle();
        check(init_o == 1 && bus_en_o == 0, "R8 cpu sets init", {init_o, bus_en_o}, 2);
        cpu(1'b0); idle(); settle();
        check(bus_en_o == 1, "R8 cpu clears init", bus_en_o, 1);

        phase = "R1";
        drive(1, 0, 0, 1, 0); idle(); settle();
        check(init_o == 1 && bus_en_o == 0, "R1 bus-off forces init", {init_o, bus_en_o}, 2);
        drive(1, 0, 0, 0, 0); idle(); settle();
        check(init_o == 1 && run_cnt_o == 0, "R1 repeat bus-off ignored", init_o, 1);

        phase = "R2";
        recs(30); idle(); settle();
        check(run_cnt_o == 0, "R2 no count before init cleared", run_cnt_o, 0);
        cpu(1'b1); recs(12); idle(); settle();
        check(run_cnt_o == 0 && init_o == 1, "R2 init=1 keeps waiting", run_cnt_o, 0);
        cpu(1'b0); idle(); settle();
        check(init_o == 0 && bus_en_o == 0, "R2 recovery started, bus held", {init_o, bus_en_o}, 0);

        phase = "R4";
        recs(10);
        for (int i = 0; i < 4; i++) idle();
        sbit(1'b1); settle();
        check(run_cnt_o == 1 && lec_bit0_o == 1, "R4 invalid cycles ignored, run done", run_cnt_o, 1);
        idle(); settle();
        check(lec_bit0_o == 0, "R4 strobe lasts one cycle", lec_bit0_o, 0);

        phase = "R5";
        recs(5); sbit(1'b0); recs(10); idle(); settle();
        check(run_cnt_o == 1, "R5 dominant restarts partial run", run_cnt_o, 1);
        sbit(1'b1); idle(); settle();
        check(run_cnt_o == 2, "R5 run after dominant", run_cnt_o, 2);
        recs(22); idle(); settle();
        check(run_cnt_o == 4, "R5 22 recessive make two runs", run_cnt_o, 4);

        phase = "R3";
        recs(6); cpu(1'b1); recs(20); idle(); settle();
        check(run_cnt_o == 4 && init_o == 1, "R3 paused count held", run_cnt_o, 4);
        cpu(1'b0); recs(4); idle(); settle();
        check(run_cnt_o == 4, "R3 partial run kept, not yet done", run_cnt_o, 4);
        sbit(1'b1); idle(); settle();
        check(run_cnt_o == 5, "R3 resumed run completes", run_cnt_o, 5);

        phase = "R6";
        for (int r = 5; r < RUNS - 1; r++) recs(RLEN);
        recs(RLEN - 1); idle(); settle();
        check(run_cnt_o == RUNS - 1 && !err_reset_o, "R6 one short of last run", run_cnt_o, RUNS - 1);
        sbit(1'b1); settle();
        check(run_cnt_o == RUNS && err_reset_o && lec_bit0_o, "R6 last run resets counters", run_cnt_o, RUNS);
        idle(); settle();
        check(run_cnt_o == 0 && !err_reset_o && bus_en_o, "R6 back to normal", run_cnt_o, 0);
        recs(RLEN); idle(); settle();
        check(run_cnt_o == 0, "R6 normal again, no counting", run_cnt_o, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule